// File: doc/BRIEF.md
# Logical Device Configuration and I/O Range Decoder

This block holds the configuration state of one logical device on a legacy I/O bus and answers bus cycles on the device's behalf. A configuration controller writes and reads the bank through a byte-wide index/data port. The bank holds an enable bit, a conflict-probe control, eight I/O base addresses, two interrupt settings and two DMA channel selects. The interrupt and DMA fields are presented on plain output pins for routing logic elsewhere.

Bus cycles come in on a valid/ready request channel that carries a 16-bit address and a read/write flag. The block returns exactly one result per accepted request, in order, on a valid/ready response channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response register is empty or is being drained in the same cycle. A response that is stalled by a low `rsp_ready` keeps its contents unchanged. The response says whether the device claimed the cycle as live hardware, whether it answered as a conflict probe, which range matched, and which data byte a probe drives.

A probe lets software find address clashes before it turns the device on. While the device is off and probing is enabled, reads inside a programmed range return a known byte. While the device is enabled, a hit selects the device. With both bits set, neither happens.

Top module: `ldev_cfg_decoder`

## Requirements
- R1: After reset the enable bit, the probe controls, all I/O bases and all interrupt levels and types read as zero, both DMA selects read as 4 (no channel), and no cycle is claimed.
- R2: Index 0x30 holds the enable bit in bit 0; bits 7:1 always read as zero.
- R3: Index 0x31 holds probe enable in bit 1 and the pattern select in bit 0; bits 7:2 always read as zero.
- R4: I/O range i (0 to 7) has its base address bits 15:8 at index 0x60+2i and bits 7:0 at index 0x61+2i, and each byte reads back as written.
- R5: Interrupt entry i (0 or 1) keeps a level in bits 3:0 of index 0x70+2i (upper bits read zero, 0 means unused) and a type byte at 0x71+2i whose bit 1 is polarity (1 = high) and bit 0 is trigger (1 = level). The entries drive `irq_level`, `irq_pol` and `irq_trig` (entry i in slice i).
- R6: DMA select i (0 or 1) sits in bits 2:0 of index 0x74+i (upper bits read zero) and drives slice i of `dma_chan`.
- R7: Range i matches an address A when its base B is nonzero and B <= A < B+RANGE_LEN (RANGE_LEN = 8 by default, computed without 16-bit wrap). When several ranges match, the lowest index wins.
- R8: With the enable bit set and probing off, every matching read or write returns `rsp_sel`=1, `rsp_probe`=0, `rsp_data`=0 and `rsp_range` = the matching index, and `dev_active` is 1.
- R9: With the enable bit clear and probing on, a matching read returns `rsp_probe`=1, `rsp_sel`=0, the matching index, and data 0x55 when the pattern select is 1 or 0xAA when it is 0. Writes and misses are not claimed.
- R10: With the enable bit and probe enable both set, no cycle is claimed and `dev_active` stays 0.
- R11: With the enable bit and probe enable both clear, no cycle is claimed. An unclaimed response carries `rsp_sel`=0, `rsp_probe`=0, `rsp_data`=0 and `rsp_range`=0.
- R12: Each accepted request yields one response, in order. `req_ready` is low while a response waits with `rsp_ready` low, and a stalled response keeps its fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_index | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data for `cfg_index` (combinational) |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted this cycle |
| req_addr | input | 16 | Bus cycle I/O address |
| req_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_sel | output | 1 | Cycle claimed by the live device |
| rsp_probe | output | 1 | Cycle answered as a conflict probe |
| rsp_data | output | 8 | Probe data byte, zero otherwise |
| rsp_range | output | 3 | Index of the matching range when claimed |
| dev_active | output | 1 | Device is live (enabled and probe off) |
| irq_level | output | 8 | Interrupt levels, 4 bits per entry |
| irq_pol | output | 2 | Interrupt polarity per entry |
| irq_trig | output | 2 | Interrupt trigger type per entry |
| dma_chan | output | 6 | DMA channel selects, 3 bits per entry |

## Verification
The hardest situation to reach is an address that falls inside two overlapping ranges while a response is stalled. In that case the priority choice has to be captured once and then held. The stimulus programs range 0 and range 3 four bytes apart, range 7 at the top of the address space, and leaves every other base at zero. It then sends bursts of reads and writes at the overlap, at both edges of each range and at address 0, while a pseudo-random sequence drops `rsp_ready`. The same bursts are repeated in each of the four combinations of enable and probe bits, and with both probe patterns.

// File: rtl/ldev_pkg.sv
package ldev_pkg;

  // configuration index map; neighbours decode these positions
  localparam logic [7:0] IX_ENABLE   = 8'h30;
  localparam logic [7:0] IX_PROBE    = 8'h31;
  localparam logic [7:0] IX_IO_BASE  = 8'h60;
  localparam logic [7:0] IX_IRQ      = 8'h70;
  localparam logic [7:0] IX_DMA      = 8'h74;

  localparam logic [7:0] PROBE_BYTE_SET = 8'h55;
  localparam logic [7:0] PROBE_BYTE_CLR = 8'hAA;
  localparam logic [2:0] DMA_NONE       = 3'd4;

  typedef enum logic [1:0] {
    MODE_IDLE    = 2'd0,
    MODE_LIVE    = 2'd1,
    MODE_PROBE   = 2'd2,
    MODE_BLOCKED = 2'd3
  } ldev_mode_e;

  function automatic logic [7:0] ix_at(input logic [7:0] base_ix, input int unsigned off);
    logic [31:0] o;
    o = off;
    return base_ix + o[7:0];
  endfunction

endpackage

// File: rtl/ldev_regbank.sv
module ldev_regbank
  import ldev_pkg::*;
#(
  parameter int NUM_IO  = 8,
  parameter int NUM_IRQ = 2,
  parameter int NUM_DMA = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [7:0]             index,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  output logic [NUM_IO*16-1:0]   base_flat,
  output logic [NUM_IRQ*4-1:0]   irq_level,
  output logic [NUM_IRQ-1:0]     irq_pol,
  output logic [NUM_IRQ-1:0]     irq_trig,
  output logic [NUM_DMA*3-1:0]   dma_chan,
  output logic                   pat_set,
  output ldev_mode_e             mode
);

  logic        enable_q;
  logic        probe_en_q;
  logic        pat_q;
  logic [15:0] base_q [NUM_IO];
  logic [3:0]  lvl_q  [NUM_IRQ];
  logic [1:0]  typ_q  [NUM_IRQ];
  logic [2:0]  dma_q  [NUM_DMA];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q   <= 1'b0;
      probe_en_q <= 1'b0;
      pat_q      <= 1'b0;
      for (int i = 0; i < NUM_IO; i++)  base_q[i] <= '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        lvl_q[i] <= '0;
        typ_q[i] <= '0;
      end
      for (int i = 0; i < NUM_DMA; i++) dma_q[i] <= DMA_NONE;
    end else if (wr_en) begin
      if (index == IX_ENABLE) enable_q <= wdata[0];
      if (index == IX_PROBE) begin
        probe_en_q <= wdata[1];
        pat_q      <= wdata[0];
      end
      for (int i = 0; i < NUM_IO; i++) begin
        if (index == ix_at(IX_IO_BASE, 2*i))     base_q[i][15:8] <= wdata;
        if (index == ix_at(IX_IO_BASE, 2*i + 1)) base_q[i][7:0]  <= wdata;
      end
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (index == ix_at(IX_IRQ, 2*i))     lvl_q[i] <= wdata[3:0];
        if (index == ix_at(IX_IRQ, 2*i + 1)) typ_q[i] <= wdata[1:0];
      end
      for (int i = 0; i < NUM_DMA; i++) begin
        if (index == ix_at(IX_DMA, i)) dma_q[i] <= wdata[2:0];
      end
    end
  end

  // combinational readback; unmapped indices return zero
  always_comb begin
    rdata = 8'h00;
    if (index == IX_ENABLE) rdata = {7'b0, enable_q};
    if (index == IX_PROBE)  rdata = {6'b0, probe_en_q, pat_q};
    for (int i = 0; i < NUM_IO; i++) begin
      if (index == ix_at(IX_IO_BASE, 2*i))     rdata = base_q[i][15:8];
      if (index == ix_at(IX_IO_BASE, 2*i + 1)) rdata = base_q[i][7:0];
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (index == ix_at(IX_IRQ, 2*i))     rdata = {4'b0, lvl_q[i]};
      if (index == ix_at(IX_IRQ, 2*i + 1)) rdata = {6'b0, typ_q[i]};
    end
    for (int i = 0; i < NUM_DMA; i++) begin
      if (index == ix_at(IX_DMA, i)) rdata = {5'b0, dma_q[i]};
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_IO; g++) begin : g_base
      assign base_flat[g*16 +: 16] = base_q[g];
    end
    for (g = 0; g < NUM_IRQ; g++) begin : g_irq
      assign irq_level[g*4 +: 4] = lvl_q[g];
      assign irq_pol[g]          = typ_q[g][1];
      assign irq_trig[g]         = typ_q[g][0];
    end
    for (g = 0; g < NUM_DMA; g++) begin : g_dma
      assign dma_chan[g*3 +: 3] = dma_q[g];
    end
  endgenerate

  // enabling is held off while probing is on, and vice versa
  always_comb begin
    unique case ({enable_q, probe_en_q})
      2'b10:   mode = MODE_LIVE;
      2'b01:   mode = MODE_PROBE;
      2'b11:   mode = MODE_BLOCKED;
      default: mode = MODE_IDLE;
    endcase
  end

  assign pat_set = pat_q;

  AST_ENABLE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && index == IX_ENABLE) |=> (rdata[7:1] == 7'b0 || index != IX_ENABLE)); // R2

  AST_DMA_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && index == IX_DMA) |=> (dma_chan[2:0] == $past(wdata[2:0]))); // R6

  AST_MODE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && index == IX_ENABLE && wdata[0] && probe_en_q) |=> (mode != MODE_LIVE)); // R10

endmodule

// File: rtl/ldev_range_match.sv
module ldev_range_match #(
  parameter int NUM_IO    = 8,
  parameter int RANGE_LEN = 8,
  parameter int IW        = 3
) (
  input  logic [NUM_IO*16-1:0] base_flat,
  input  logic [15:0]          addr,
  output logic                 hit_any,
  output logic [IW-1:0]        hit_idx
);

  localparam logic [16:0] LEN17 = 17'(RANGE_LEN);

  logic [NUM_IO-1:0] hit_vec;

  genvar g;
  generate
    for (g = 0; g < NUM_IO; g++) begin : g_cmp
      logic [16:0] lo;
      logic [16:0] hi;
      logic [16:0] a17;
      assign lo  = {1'b0, base_flat[g*16 +: 16]};
      assign hi  = lo + LEN17;
      assign a17 = {1'b0, addr};
      assign hit_vec[g] = (lo != 17'd0) && (a17 >= lo) && (a17 < hi);
    end
  endgenerate

  // lowest index has priority
  always_comb begin
    hit_any = |hit_vec;
    hit_idx = '0;
    for (int i = NUM_IO - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

  always_comb begin
    if (hit_any) begin
      AST_PICK_IS_HIT: assert (hit_vec[hit_idx]); // R7
    end
  end

endmodule

// File: rtl/ldev_bus_resp.sv
module ldev_bus_resp
  import ldev_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_rd,
  input  logic          hit_any,
  input  logic [IW-1:0] hit_idx,
  input  ldev_mode_e    mode,
  input  logic          pat_set,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_sel,
  output logic          rsp_probe,
  output logic [7:0]    rsp_data,
  output logic [IW-1:0] rsp_range
);

  logic accept;
  logic claim_live;
  logic claim_probe;

  assign req_ready   = !rsp_valid || rsp_ready;
  assign accept      = req_valid && req_ready;
  assign claim_live  = (mode == MODE_LIVE) && hit_any;
  assign claim_probe = (mode == MODE_PROBE) && hit_any && req_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_sel   <= 1'b0;
      rsp_probe <= 1'b0;
      rsp_data  <= 8'h00;
      rsp_range <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_sel   <= claim_live;
      rsp_probe <= claim_probe;
      rsp_data  <= claim_probe ? (pat_set ? PROBE_BYTE_SET : PROBE_BYTE_CLR) : 8'h00;
      rsp_range <= (claim_live || claim_probe) ? hit_idx : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_sel) && $stable(rsp_probe)
                                   && $stable(rsp_data) && $stable(rsp_range))); // R12

  AST_QUIET_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (mode == MODE_IDLE || mode == MODE_BLOCKED)) |=> (!rsp_sel && !rsp_probe)); // R11

  AST_WRITE_NO_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_rd) |=> !rsp_probe); // R9

  AST_LIVE_NO_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == MODE_LIVE) |=> (!rsp_probe && rsp_data == 8'h00)); // R8

endmodule

// File: rtl/ldev_cfg_decoder.sv
module ldev_cfg_decoder
  import ldev_pkg::*;
#(
  parameter int NUM_IO    = 8,
  parameter int NUM_IRQ   = 2,
  parameter int NUM_DMA   = 2,
  parameter int RANGE_LEN = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr,
  input  logic [7:0]                  cfg_index,
  input  logic [7:0]                  cfg_wdata,
  output logic [7:0]                  cfg_rdata,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [15:0]                 req_addr,
  input  logic                        req_rd,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic                        rsp_sel,
  output logic                        rsp_probe,
  output logic [7:0]                  rsp_data,
  output logic [$clog2(NUM_IO)-1:0]   rsp_range,
  output logic                        dev_active,
  output logic [NUM_IRQ*4-1:0]        irq_level,
  output logic [NUM_IRQ-1:0]          irq_pol,
  output logic [NUM_IRQ-1:0]          irq_trig,
  output logic [NUM_DMA*3-1:0]        dma_chan
);

  localparam int IW = $clog2(NUM_IO);

  logic [NUM_IO*16-1:0] base_flat;
  logic                 pat_set;
  ldev_mode_e           mode;
  logic                 hit_any;
  logic [IW-1:0]        hit_idx;

  ldev_regbank #(
    .NUM_IO  (NUM_IO),
    .NUM_IRQ (NUM_IRQ),
    .NUM_DMA (NUM_DMA)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .index     (cfg_index),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .base_flat (base_flat),
    .irq_level (irq_level),
    .irq_pol   (irq_pol),
    .irq_trig  (irq_trig),
    .dma_chan  (dma_chan),
    .pat_set   (pat_set),
    .mode      (mode)
  );

  ldev_range_match #(
    .NUM_IO    (NUM_IO),
    .RANGE_LEN (RANGE_LEN),
    .IW        (IW)
  ) u_match (
    .base_flat (base_flat),
    .addr      (req_addr),
    .hit_any   (hit_any),
    .hit_idx   (hit_idx)
  );

  ldev_bus_resp #(
    .IW (IW)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_rd    (req_rd),
    .hit_any   (hit_any),
    .hit_idx   (hit_idx),
    .mode      (mode),
    .pat_set   (pat_set),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_sel   (rsp_sel),
    .rsp_probe (rsp_probe),
    .rsp_data  (rsp_data),
    .rsp_range (rsp_range)
  );

  assign dev_active = (mode == MODE_LIVE);

  AST_ACTIVE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_index == IX_PROBE && cfg_wdata[1]) |=> !dev_active); // R10

endmodule

// File: tb/ldev_cfg_decoder_bench.sv
module ldev_cfg_decoder_bench;

  localparam int LEN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_index = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = 16'h0;
  logic        req_rd = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_sel, rsp_probe;
  logic [7:0]  rsp_data;
  logic [2:0]  rsp_range;
  logic        dev_active;
  logic [7:0]  irq_level;
  logic [1:0]  irq_pol, irq_trig;
  logic [5:0]  dma_chan;

  always #2 clk = ~clk;

  ldev_cfg_decoder u_ldev_cfg_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_index(cfg_index),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_rd(req_rd),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_sel(rsp_sel),
    .rsp_probe(rsp_probe), .rsp_data(rsp_data), .rsp_range(rsp_range),
    .dev_active(dev_active), .irq_level(irq_level), .irq_pol(irq_pol),
    .irq_trig(irq_trig), .dma_chan(dma_chan)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench model of the configuration, written from the requirements
  logic [15:0] m_base [8];
  logic        m_en = 1'b0, m_prb = 1'b0, m_pat = 1'b0;

  task automatic cfg_write(input logic [7:0] ix, input logic [7:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_index = ix; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    if (ix == 8'h30) m_en = d[0];
    if (ix == 8'h31) begin m_prb = d[1]; m_pat = d[0]; end
    for (int i = 0; i < 8; i++) begin
      if (ix == 8'(8'h60 + 2*i)) m_base[i][15:8] = d;
      if (ix == 8'(8'h61 + 2*i)) m_base[i][7:0]  = d;
    end
  endtask

  task automatic cfg_check(input string tag, input logic [7:0] ix, input logic [7:0] exp);
    #1 cfg_index = ix;
    #1 check(tag, {24'b0, cfg_rdata}, {24'b0, exp});
  endtask

  // expected response packed as {sel, probe, data, range}
  logic [12:0] sb_q [$];

  function automatic logic [12:0] expect_rsp(input logic [15:0] a, input logic rd);
    int hit;
    logic sel, prb;
    logic [7:0] d;
    logic [2:0] r;
    hit = -1;
    for (int i = 7; i >= 0; i--)
      if (m_base[i] != 16'h0 && int'(a) >= int'(m_base[i]) && int'(a) < int'(m_base[i]) + LEN)
        hit = i;
    sel = m_en && !m_prb && hit >= 0;
    prb = !m_en && m_prb && hit >= 0 && rd;
    d   = prb ? (m_pat ? 8'h55 : 8'hAA) : 8'h00;
    r   = (sel || prb) ? 3'(hit) : 3'd0;
    return {sel, prb, d, r};
  endfunction

  task automatic bus_req(input logic [15:0] a, input logic rd);
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_rd = rd;
    do @(negedge clk); while (!req_ready);
    sb_q.push_back(expect_rsp(a, rd));
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic burst(input string tag);
    logic [15:0] pts [10];
    pts = '{16'h0300, 16'h0307, 16'h0308, 16'h030B, 16'h030C,
            16'h02FF, 16'h0000, 16'hFFFC, 16'hFFFF, 16'h0304};
    foreach (pts[k]) begin
      bus_req(pts[k], 1'b1);
      bus_req(pts[k], 1'b0);
    end
    wait (sb_q.size() == 0);
    @(negedge clk);
    check({tag, " R12 drained"}, {31'b0, rsp_valid && rsp_ready}, 32'd0);
  endtask

  // response pacing for back-pressure
  logic [7:0] lfsr = 8'hA5;
  bit stall_on = 1'b0;
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_ready = stall_on ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && rsp_valid && !rsp_ready)
      check("R12 ready low while stalled", {31'b0, req_ready}, 32'd0);
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb_q.size() == 0) check("R12 unexpected response", 32'd1, 32'd0);
      else begin
        logic [12:0] e;
        e = sb_q.pop_front();
        check("R7-decode sel R8",   {31'b0, rsp_sel},   {31'b0, e[12]});
        check("R7-decode probe R9", {31'b0, rsp_probe}, {31'b0, e[11]});
        check("R9 data",            {24'b0, rsp_data},  {24'b0, e[10:3]});
        check("R7 range",           {29'b0, rsp_range}, {29'b0, e[2:0]});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog expired", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_base[i] = 16'h0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);

    // R1 reset state
    cfg_check("R1 enable", 8'h30, 8'h00);
    cfg_check("R1 probe", 8'h31, 8'h00);
    for (int i = 0; i < 16; i++) cfg_check("R1 base", 8'(8'h60 + i), 8'h00);
    for (int i = 0; i < 4; i++)  cfg_check("R1 irq", 8'(8'h70 + i), 8'h00);
    cfg_check("R1 dma0", 8'h74, 8'h04);
    cfg_check("R1 dma1", 8'h75, 8'h04);
    check("R1 dma pins", {26'b0, dma_chan}, 32'h24);
    check("R1 irq pins", {20'b0, irq_level, irq_pol, irq_trig}, 32'h0);
    check("R1 dev_active", {31'b0, dev_active}, 32'd0);

    // R2 / R3 reserved bits
    cfg_write(8'h30, 8'hFF); cfg_check("R2 enable bits", 8'h30, 8'h01);
    cfg_write(8'h30, 8'h00); cfg_check("R2 enable clear", 8'h30, 8'h00);
    cfg_write(8'h31, 8'hFF); cfg_check("R3 probe bits", 8'h31, 8'h03);
    cfg_write(8'h31, 8'h00); cfg_check("R3 probe clear", 8'h31, 8'h00);

    // R4 bases: range 0 and 3 overlap, range 7 at the top
    cfg_write(8'h60, 8'h03); cfg_write(8'h61, 8'h00);
    cfg_write(8'h66, 8'h03); cfg_write(8'h67, 8'h04);
    cfg_write(8'h6E, 8'hFF); cfg_write(8'h6F, 8'hFC);
    cfg_check("R4 base0 hi", 8'h60, 8'h03);
    cfg_check("R4 base3 lo", 8'h67, 8'h04);
    cfg_check("R4 base7 hi", 8'h6E, 8'hFF);
    cfg_check("R4 base7 lo", 8'h6F, 8'hFC);
    cfg_check("R4 base5 lo", 8'h6B, 8'h00);

    // R5 interrupts
    cfg_write(8'h70, 8'hFA); cfg_write(8'h71, 8'hFF);
    cfg_write(8'h72, 8'h05); cfg_write(8'h73, 8'h01);
    cfg_check("R5 lvl0", 8'h70, 8'h0A);
    cfg_check("R5 type0", 8'h71, 8'h03);
    check("R5 level pins", {24'b0, irq_level}, 32'h5A);
    check("R5 pol pins",   {30'b0, irq_pol},   32'h1);
    check("R5 trig pins",  {30'b0, irq_trig},  32'h3);

    // R6 dma
    cfg_write(8'h74, 8'hFB);
    cfg_check("R6 dma0", 8'h74, 8'h03);
    cfg_check("R6 dma1", 8'h75, 8'h04);
    check("R6 dma pins", {26'b0, dma_chan}, 32'h23);

    stall_on = 1'b1;
    burst("R11 idle");
    cfg_write(8'h31, 8'h03);
    burst("R9 probe 55");
    cfg_write(8'h31, 8'h02);
    burst("R9 probe AA");
    cfg_write(8'h30, 8'h01);
    check("R10 dev_active", {31'b0, dev_active}, 32'd0);
    burst("R10 blocked");
    cfg_write(8'h31, 8'h00);
    check("R8 dev_active", {31'b0, dev_active}, 32'd1);
    burst("R8 live");
    stall_on = 1'b0;
    burst("R8 live no stall");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule